// File: doc/BRIEF.md
# Shared-Offset Host FIFO Data Port

This block is the data window that a host sees at a single register offset in front of a pair of opposite-direction FIFOs. A host write at that offset feeds the host-to-add-on FIFO, and a host read at the same offset drains the add-on-to-host FIFO. Because the two directions use separate storage, the host can never read back a value it has just written. The add-on side has its own plain push and pop strobes.

Hosts may access the port in byte or halfword pieces. A 32-bit entry moves only when the access carries the final byte lane of the selected lane order. Earlier write lanes collect in a staging register, and earlier read lanes return the current head without consuming it. One configuration input picks ascending order, where byte 3 is last, or descending order, where byte 0 is last.

Full, half-full and empty flags for each direction are provided for a status register. Three sticky error bits record a dropped push, an empty pop, and any access made while a bus-master transfer is running.

Top module: `hostq_port`

## Requirements
- R1: While reset is asserted and after it is released, both FIFOs are empty, each status triple reads 3'b001, and all three sticky bits are low.
- R2: A write at offset 8'h20 with all four byte enables pushes the whole dword. The add-on side then sees it at `addon_rdata`, in first-in first-out order.
- R3: A read at offset 8'h20 returns the head of the add-on-to-host FIFO, never the host's written data. `acc_rdata` is zero whenever there is no valid port read.
- R4: With `lane_desc`=0 (ascending), a write pushes only when `acc_be[3]` is set. Lanes written earlier are held and merged, each by its byte position, into the pushed entry. The staging register then clears.
- R5: With `lane_desc`=1 (descending), the last lane is byte 0. A push happens only when `acc_be[0]` is set.
- R6: A port read pops only when it enables the last lane of the selected order. Reads of other lanes return the head without advancing it.
- R7: A host push when the host-to-add-on FIFO is full is dropped, leaving its contents unchanged, and sets sticky `ovf_flag`. This holds even if the add-on pops in the same cycle, because fullness is judged before the edge.
- R8: A popping read when the add-on-to-host FIFO is empty returns zero and sets sticky `unf_flag`.
- R9: Each status triple is {full, half, empty}, with full = count equals DEPTH, half = count at least DEPTH/2, and empty = count zero. It reflects the count from the clock edge after a push or pop.
- R10: While `bm_active` is high, a port access changes no FIFO or staging state and reads zero. It also sets sticky `busy_err`.
- R11: An access at any offset other than 8'h20 has no effect.
- R12: An add-on push and a host popping read of the add-on-to-host FIFO in the same cycle both take effect. If that FIFO was empty before the edge, the read returns zero and flags underflow, and the pushed word is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Host access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Host byte offset |
| acc_be | input | 4 | Byte lane enables |
| acc_wdata | input | 32 | Host write data, lane-aligned |
| acc_rdata | output | 32 | Host read data (combinational) |
| lane_desc | input | 1 | Lane order: 0 ascending, 1 descending |
| bm_active | input | 1 | Bus-master transfer in progress |
| addon_pop | input | 1 | Add-on pops the host-to-add-on FIFO |
| addon_rdata | output | 32 | Head of the host-to-add-on FIFO |
| addon_push | input | 1 | Add-on pushes the add-on-to-host FIFO |
| addon_wdata | input | 32 | Add-on push data |
| h2a_stat | output | 3 | {full, half, empty} of host-to-add-on FIFO |
| a2h_stat | output | 3 | {full, half, empty} of add-on-to-host FIFO |
| ovf_flag | output | 1 | Sticky dropped-push flag |
| unf_flag | output | 1 | Sticky empty-pop flag |
| busy_err | output | 1 | Sticky access-during-bus-master flag |

## Verification
Two functions can land on the same edge and are provoked on purpose. The first is a host popping read together with an add-on push on the add-on-to-host FIFO, tried once with that FIFO holding an entry and once with it empty. The second is a host push together with an add-on pop while the host-to-add-on FIFO is full. In each case the bench's queue model applies the rules from the pre-edge fill level and compares the read data, the head word, the status triples and the sticky bits on every clock. Any disagreement about which side won shows up as a wrong count or a wrong head word.

// File: rtl/hostq_pkg.sv
package hostq_pkg;
  localparam int unsigned LANES  = 4;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned DW     = LANES * LANE_W;

  typedef enum logic {
    LANE_ASC  = 1'b0,
    LANE_DESC = 1'b1
  } lane_order_e;

  typedef struct packed {
    logic full;
    logic half;
    logic empty;
  } fifo_flags_t;
endpackage

// File: rtl/hostq_rst_sync.sv
module hostq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/hostq_fifo.sv
module hostq_fifo
  import hostq_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output fifo_flags_t      flags_o
);
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW   = AW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);
  localparam logic [AW-1:0] LAST_IX  = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  fifo_flags_t      flags_q, flags_d;
  logic             push_ok, pop_ok;

  always_comb begin
    push_ok  = push_i & ~flags_q.full;
    pop_ok   = pop_i  & ~flags_q.empty;
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    if (push_ok) wr_ptr_d = (wr_ptr_q == LAST_IX) ? '0 : wr_ptr_q + AW'(1);
    if (pop_ok)  rd_ptr_d = (rd_ptr_q == LAST_IX) ? '0 : rd_ptr_q + AW'(1);
    cnt_d = cnt_q + CW'(push_ok) - CW'(pop_ok);
    flags_d.full  = (cnt_d == FULL_CNT);
    flags_d.half  = (cnt_d >= HALF_CNT);
    flags_d.empty = (cnt_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      flags_q  <= '{full: 1'b0, half: 1'b0, empty: 1'b1};
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
      flags_q  <= flags_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr_q] <= wdata_i;
  end

  assign rdata_o = mem[rd_ptr_q];
  assign flags_o = flags_q;

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q.full && push_i && !pop_i) |=> flags_q.full); // R7
  AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q.empty && pop_i && !push_i) |=> flags_q.empty); // R8
endmodule

// File: rtl/hostq_wpack.sv
module hostq_wpack
  import hostq_pkg::*;
#(
  parameter int unsigned NLANE = LANES,
  parameter int unsigned LW    = LANE_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_hit_i,
  input  logic [NLANE-1:0]         be_i,
  input  logic [NLANE*LW-1:0]      wdata_i,
  input  logic [$clog2(NLANE)-1:0] last_lane_i,
  output logic                     push_o,
  output logic [NLANE*LW-1:0]      pdata_o
);
  logic [NLANE*LW-1:0] stage_q, stage_d, merged;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign merged[g*LW +: LW] = be_i[g] ? wdata_i[g*LW +: LW] : stage_q[g*LW +: LW];
  end

  always_comb begin
    push_o  = wr_hit_i & be_i[last_lane_i];
    stage_d = stage_q;
    if (push_o)        stage_d = '0;
    else if (wr_hit_i) stage_d = merged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign pdata_o = merged;
endmodule

// File: rtl/hostq_port.sv
module hostq_port
  import hostq_pkg::*;
#(
  parameter int unsigned     ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] PORT_OFFSET = ADDR_W'(8'h20),
  parameter int unsigned     DEPTH       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [3:0]        acc_be,
  input  logic [31:0]       acc_wdata,
  output logic [31:0]       acc_rdata,
  input  logic              lane_desc,
  input  logic              bm_active,
  input  logic              addon_pop,
  output logic [31:0]       addon_rdata,
  input  logic              addon_push,
  input  logic [31:0]       addon_wdata,
  output logic [2:0]        h2a_stat,
  output logic [2:0]        a2h_stat,
  output logic              ovf_flag,
  output logic              unf_flag,
  output logic              busy_err
);
  localparam int unsigned LIX_W = $clog2(LANES);

  logic              rst_s_n;
  lane_order_e       order;
  logic [LIX_W-1:0]  last_ix;
  logic              port_hit, clean, wr_hit, rd_hit, rd_pop;
  logic              h2a_push;
  logic [DW-1:0]     h2a_pdata, a2h_head;
  fifo_flags_t       h2a_flags, a2h_flags;
  logic              ovf_q, ovf_d, unf_q, unf_d, berr_q, berr_d;

  hostq_rst_sync i_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n));

  always_comb begin
    order    = lane_order_e'(lane_desc);
    last_ix  = (order == LANE_DESC) ? LIX_W'(0) : LIX_W'(LANES - 1);
    port_hit = acc_valid & (acc_addr == PORT_OFFSET);
    clean    = port_hit & ~bm_active;
    wr_hit   = clean & acc_write;
    rd_hit   = clean & ~acc_write;
    rd_pop   = rd_hit & acc_be[last_ix];
  end

  hostq_wpack i_wpack (
    .clk(clk), .rst_n(rst_s_n), .wr_hit_i(wr_hit), .be_i(acc_be),
    .wdata_i(acc_wdata), .last_lane_i(last_ix),
    .push_o(h2a_push), .pdata_o(h2a_pdata)
  );

  hostq_fifo #(.WIDTH(DW), .DEPTH(DEPTH)) i_h2a (
    .clk(clk), .rst_n(rst_s_n), .push_i(h2a_push), .wdata_i(h2a_pdata),
    .pop_i(addon_pop), .rdata_o(addon_rdata), .flags_o(h2a_flags)
  );

  hostq_fifo #(.WIDTH(DW), .DEPTH(DEPTH)) i_a2h (
    .clk(clk), .rst_n(rst_s_n), .push_i(addon_push), .wdata_i(addon_wdata),
    .pop_i(rd_pop), .rdata_o(a2h_head), .flags_o(a2h_flags)
  );

  always_comb begin
    ovf_d  = ovf_q  | (h2a_push & h2a_flags.full);
    unf_d  = unf_q  | (rd_pop & a2h_flags.empty);
    berr_d = berr_q | (port_hit & bm_active);
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
      berr_q <= 1'b0;
    end else begin
      ovf_q  <= ovf_d;
      unf_q  <= unf_d;
      berr_q <= berr_d;
    end
  end

  assign acc_rdata = (rd_hit & ~a2h_flags.empty) ? a2h_head : '0;
  assign h2a_stat  = h2a_flags;
  assign a2h_stat  = a2h_flags;
  assign ovf_flag  = ovf_q;
  assign unf_flag  = unf_q;
  assign busy_err  = berr_q;

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_s_n)
    ovf_flag |=> ovf_flag); // R7
  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_s_n)
    unf_flag |=> unf_flag); // R8
  AST_BUSY_STICKY: assert property (@(posedge clk) disable iff (!rst_s_n)
    busy_err |=> busy_err); // R10
  AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (!rst_s_n)
    (port_hit && bm_active && !addon_pop && !addon_push)
      |=> ($stable(h2a_stat) && $stable(a2h_stat))); // R10
  AST_MISS_FROZEN: assert property (@(posedge clk) disable iff (!rst_s_n)
    (acc_valid && acc_addr != PORT_OFFSET && !addon_pop && !addon_push)
      |=> ($stable(h2a_stat) && $stable(a2h_stat))); // R11
endmodule

// File: tb/test_hostq_port.sv
`timescale 1ns/1ps
module test_hostq_port;
  localparam int D = 8;
  localparam logic [7:0] OFF = 8'h20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_valid = 0, acc_write = 0, lane_desc = 0, bm_active = 0;
  logic addon_pop = 0, addon_push = 0;
  logic [7:0]  acc_addr = 0;
  logic [3:0]  acc_be = 0;
  logic [31:0] acc_wdata = 0, addon_wdata = 0;
  logic [31:0] acc_rdata, addon_rdata;
  logic [2:0]  h2a_stat, a2h_stat;
  logic        ovf_flag, unf_flag, busy_err;

  hostq_port #(.ADDR_W(8), .PORT_OFFSET(8'h20), .DEPTH(D)) i_hostq_port (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_be(acc_be), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .lane_desc(lane_desc), .bm_active(bm_active), .addon_pop(addon_pop),
    .addon_rdata(addon_rdata), .addon_push(addon_push), .addon_wdata(addon_wdata),
    .h2a_stat(h2a_stat), .a2h_stat(a2h_stat), .ovf_flag(ovf_flag),
    .unf_flag(unf_flag), .busy_err(busy_err)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] h2a_q[$], a2h_q[$];
  logic [31:0] m_stage = 0;
  bit m_ovf = 0, m_unf = 0, m_berr = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] stat_of(input int n);
    return {n == D, n >= D / 2, n == 0};
  endfunction

  task automatic cyc(input string tag, input bit v, input bit w, input logic [7:0] addr,
                     input logic [3:0] be, input logic [31:0] wd,
                     input bit apop, input bit apush, input logic [31:0] awd);
    int hs, as_n, last;
    bit hit;
    logic [31:0] exp_rd;
    acc_valid = v; acc_write = w; acc_addr = addr; acc_be = be; acc_wdata = wd;
    addon_pop = apop; addon_push = apush; addon_wdata = awd;
    #1;
    hs = h2a_q.size(); as_n = a2h_q.size();
    hit  = v && (addr == OFF);
    last = lane_desc ? 0 : 3;
    exp_rd = (hit && !w && !bm_active && as_n > 0) ? a2h_q[0] : 32'h0;
    chk({tag, " rdata"}, acc_rdata, exp_rd);
    if (hit && bm_active) m_berr = 1;
    else if (hit && w) begin
      for (int i = 0; i < 4; i++) if (be[i]) m_stage[i*8 +: 8] = wd[i*8 +: 8];
      if (be[last]) begin
        if (hs == D) m_ovf = 1; else h2a_q.push_back(m_stage);
        m_stage = 0;
      end
    end else if (hit && !w && be[last]) begin
      if (as_n == 0) m_unf = 1; else void'(a2h_q.pop_front());
    end
    if (apop && hs > 0) void'(h2a_q.pop_front());
    if (apush && as_n < D) a2h_q.push_back(awd);
    @(posedge clk);
    @(negedge clk);
    acc_valid = 0; addon_pop = 0; addon_push = 0;
    chk({tag, " status"}, {23'd0, h2a_stat, a2h_stat, ovf_flag, unf_flag, busy_err},
        {23'd0, stat_of(h2a_q.size()), stat_of(a2h_q.size()), m_ovf, m_unf, m_berr});
    if (h2a_q.size() > 0) chk({tag, " head"}, addon_rdata, h2a_q[0]);
  endtask

  task automatic idle(input string tag);
    cyc(tag, 0, 0, 8'h00, 4'h0, 32'h0, 0, 0, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 in reset", {29'd0, h2a_stat}, 32'h1);
    chk("R1 in reset", {29'd0, a2h_stat}, 32'h1);
    chk("R1 in reset", {29'd0, ovf_flag, unf_flag, busy_err}, 32'h0);
    rst_n = 1'b1;
    repeat (3) idle("R1 after release");
    // R2 full-dword push
    cyc("R2", 1, 1, OFF, 4'hF, 32'h11223344, 0, 0, 0);
    cyc("R2", 1, 1, OFF, 4'hF, 32'h55667788, 0, 0, 0);
    cyc("R2 drain", 0, 0, 0, 0, 0, 1, 0, 0);
    cyc("R2 drain", 0, 0, 0, 0, 0, 1, 0, 0);
    // R3 separate read path
    cyc("R3", 0, 0, 0, 0, 0, 0, 1, 32'hA5A50001);
    cyc("R3", 1, 1, OFF, 4'hF, 32'hDEADBEEF, 0, 0, 0);
    cyc("R3", 1, 0, OFF, 4'hF, 0, 0, 0, 0);
    cyc("R3 drain", 0, 0, 0, 0, 0, 1, 0, 0);
    // R4 ascending byte and halfword packing
    cyc("R4", 1, 1, OFF, 4'h1, 32'h000000D4, 0, 0, 0);
    cyc("R4", 1, 1, OFF, 4'h2, 32'h0000C300, 0, 0, 0);
    cyc("R4", 1, 1, OFF, 4'h4, 32'h00B20000, 0, 0, 0);
    cyc("R4", 1, 1, OFF, 4'h8, 32'hA1000000, 0, 0, 0);
    cyc("R4", 1, 1, OFF, 4'h3, 32'h00003344, 0, 0, 0);
    cyc("R4", 1, 1, OFF, 4'hC, 32'h99880000, 0, 0, 0);
    cyc("R4 drain", 0, 0, 0, 0, 0, 1, 0, 0);
    cyc("R4 drain", 0, 0, 0, 0, 0, 1, 0, 0);
    // R5 descending lane order
    lane_desc = 1;
    cyc("R5", 1, 1, OFF, 4'h8, 32'hAA000000, 0, 0, 0);
    cyc("R5", 1, 1, OFF, 4'h4, 32'h00BB0000, 0, 0, 0);
    cyc("R5", 1, 1, OFF, 4'h2, 32'h0000CC00, 0, 0, 0);
    cyc("R5", 1, 1, OFF, 4'h1, 32'h000000DD, 0, 0, 0);
    cyc("R5 drain", 0, 0, 0, 0, 0, 1, 0, 0);
    cyc("R6 desc", 0, 0, 0, 0, 0, 0, 1, 32'h0BADF00D);
    cyc("R6 desc", 1, 0, OFF, 4'h8, 0, 0, 0, 0);
    cyc("R6 desc", 1, 0, OFF, 4'h1, 0, 0, 0, 0);
    lane_desc = 0;
    // R6 read lane sequencing
    cyc("R6", 0, 0, 0, 0, 0, 0, 1, 32'h10000001);
    cyc("R6", 0, 0, 0, 0, 0, 0, 1, 32'h20000002);
    cyc("R6", 1, 0, OFF, 4'h1, 0, 0, 0, 0);
    cyc("R6", 1, 0, OFF, 4'h2, 0, 0, 0, 0);
    cyc("R6", 1, 0, OFF, 4'h4, 0, 0, 0, 0);
    cyc("R6", 1, 0, OFF, 4'h8, 0, 0, 0, 0);
    cyc("R6", 1, 0, OFF, 4'hF, 0, 0, 0, 0);
    // R9 fill levels and R7 overflow
    for (int i = 0; i < D; i++) cyc("R9", 1, 1, OFF, 4'hF, 32'hC0DE0000 + i, 0, 0, 0);
    cyc("R7", 1, 1, OFF, 4'hF, 32'hBAD00BAD, 0, 0, 0);
    cyc("R7 full with add-on pop", 1, 1, OFF, 4'hF, 32'hBAD00BAE, 1, 0, 0);
    for (int i = 0; i < D; i++) cyc("R9 drain", 0, 0, 0, 0, 0, 1, 0, 0);
    // R8 underflow
    cyc("R8", 1, 0, OFF, 4'hF, 0, 0, 0, 0);
    // R10 bus-master busy
    bm_active = 1;
    cyc("R10", 1, 1, OFF, 4'hF, 32'h12345678, 0, 0, 0);
    cyc("R10", 1, 1, OFF, 4'h1, 32'h00000077, 0, 1, 32'h77770000);
    cyc("R10", 1, 0, OFF, 4'hF, 0, 0, 0, 0);
    bm_active = 0;
    cyc("R10 after", 1, 0, OFF, 4'hF, 0, 0, 0, 0);
    // R11 other offsets
    cyc("R11", 1, 1, 8'h24, 4'hF, 32'hFEEDFACE, 0, 0, 0);
    cyc("R11", 1, 1, 8'h1C, 4'h8, 32'hFE000000, 0, 0, 0);
    cyc("R11", 0, 0, 0, 0, 0, 0, 1, 32'h31313131);
    cyc("R11", 1, 0, 8'h1C, 4'hF, 0, 0, 0, 0);
    // R12 same-cycle host pop and add-on push
    cyc("R12 nonempty", 1, 0, OFF, 4'hF, 0, 0, 1, 32'h42424242);
    cyc("R12", 1, 0, OFF, 4'hF, 0, 0, 0, 0);
    cyc("R12 empty", 1, 0, OFF, 4'hF, 0, 0, 1, 32'h43434343);
    cyc("R12", 1, 0, OFF, 4'hF, 0, 0, 0, 0);
    idle("R12 end");
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule